// File: doc/BRIEF.md
# Bus start and stop condition generator

This block drives the start and stop conditions of a two-wire serial bus for a master. Software-style command writes control it. A single write strobe carries three command bits: master, transmit and bus-busy. The block acts on the strobe only while the interface enable input is high. With master and transmit both set, bus-busy=1 asks for a START condition and bus-busy=0 asks for a STOP condition.

A down counter steps the two open-drain lines through a setup phase and then a hold phase. The lengths of these phases come from a standard or high-speed timing set. The clock-mode input picks the set, and the block captures that input at the moment it takes the command. The bus-busy flag follows the command after its own fixed delay. When a START ends, the block pulses a clear to the external 3-bit bit counter. In the same cycle it requests one byte of clock generation from the external byte engine.

The outputs are open-drain enables. A 1 on `scl_pull` or `sda_pull` pulls that line low, and a 0 releases it, so it reads high. The block has no data stream, so every pin is a plain control or status pin.

Top module: `i2c_cond_gen`

## Requirements
- R1: A command write with `if_enable`=0 is ignored. Lines, busy flag and pulses keep their values.
- R2: START (master=1, transmit=1, busy=1): both lines are released for the setup count. Then SDA is pulled low with SCL released for the hold count. Then SCL is pulled low as well, and both stay pulled after the end.
- R3: STOP (master=1, transmit=1, busy=0): SDA is pulled low with SCL released for the setup count. Then both lines are released for the hold count, and they stay released.
- R4: Standard mode (`fast_mode`=0) counts, in clock cycles: START setup 20, STOP setup 17, hold 20, busy-flag delay 12.
- R5: High-speed mode (`fast_mode`=1) counts, in clock cycles: START setup 10, STOP setup 7, hold 10, busy-flag delay 6.
- R6: A command takes effect at clock edge k. The busy flag then takes the command's busy bit at edge k+delay, independent of when the sequence ends.
- R7: When a START completes, `bitcnt_clr` and `byte_req` each pulse for one cycle, together with `seq_done`. A STOP produces neither pulse.
- R8: Command writes that arrive while a sequence runs are ignored.
- R9: `seq_done` is a one-cycle pulse in the cycle after the last hold cycle of each sequence.
- R10: `fast_mode` is sampled at the accepted write. Later changes do not alter the running sequence.
- R11: After reset both lines are released, the busy flag is 0 and no pulse is active.
- R12: A write with master=0 or transmit=0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_enable | input | 1 | Interface enable; commands are accepted only while this is 1 |
| cmd_wr | input | 1 | Command write strobe |
| cmd_master | input | 1 | Command bit: master |
| cmd_xmit | input | 1 | Command bit: transmit |
| cmd_busy | input | 1 | Command bit: bus-busy (1 = START, 0 = STOP) |
| fast_mode | input | 1 | 1 = high-speed timing set, 0 = standard |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| bus_busy | output | 1 | Bus-busy flag |
| seq_done | output | 1 | One-cycle pulse at sequence end |
| bitcnt_clr | output | 1 | One-cycle clear for the external bit counter (to 000) |
| byte_req | output | 1 | One-cycle request for one byte of SCL clocking |

## Verification
Most faults show up directly on the lines. A wrong phase or counter value moves an SDA or SCL edge by one or more cycles. If the captured mode is wrong, a phase takes the length from the other timing set, and the first edge that should have moved is off by up to ten cycles. If the busy delay counter or its pending value is wrong, the flag changes in the wrong cycle or to the wrong value, and this shows at the sixth or twelfth cycle after the write. If a late write is accepted by mistake, the sequence restarts, and the line edges after that write differ from the expected schedule.

// File: rtl/i2c_cond_pkg.sv
`timescale 1ns/1ps
package i2c_cond_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

  typedef enum logic {
    KIND_STOP  = 1'b0,
    KIND_START = 1'b1
  } kind_e;
endpackage

// File: rtl/cond_down_cnt.sv
`timescale 1ns/1ps
// Loadable down counter: flags expiry once the loaded value has counted to zero.
module cond_down_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cond_timing.sv
`timescale 1ns/1ps
// Selects the phase lengths for the chosen timing set.
module cond_timing #(
  parameter int CNT_W        = 8,
  parameter int STD_SU_START = 20,
  parameter int STD_SU_STOP  = 17,
  parameter int STD_HOLD     = 20,
  parameter int STD_FLAG     = 12,
  parameter int FST_SU_START = 10,
  parameter int FST_SU_STOP  = 7,
  parameter int FST_HOLD     = 10,
  parameter int FST_FLAG     = 6
) (
  input  logic             fast,
  input  logic             is_start,
  output logic [CNT_W-1:0] setup_len,
  output logic [CNT_W-1:0] hold_len,
  output logic [CNT_W-1:0] flag_len
);
  localparam logic [CNT_W-1:0] S_SU_A = CNT_W'(STD_SU_START);
  localparam logic [CNT_W-1:0] S_SU_P = CNT_W'(STD_SU_STOP);
  localparam logic [CNT_W-1:0] S_HO   = CNT_W'(STD_HOLD);
  localparam logic [CNT_W-1:0] S_FL   = CNT_W'(STD_FLAG);
  localparam logic [CNT_W-1:0] F_SU_A = CNT_W'(FST_SU_START);
  localparam logic [CNT_W-1:0] F_SU_P = CNT_W'(FST_SU_STOP);
  localparam logic [CNT_W-1:0] F_HO   = CNT_W'(FST_HOLD);
  localparam logic [CNT_W-1:0] F_FL   = CNT_W'(FST_FLAG);

  always_comb begin
    if (fast) begin
      setup_len = is_start ? F_SU_A : F_SU_P;
      hold_len  = F_HO;
      flag_len  = F_FL;
    end else begin
      setup_len = is_start ? S_SU_A : S_SU_P;
      hold_len  = S_HO;
      flag_len  = S_FL;
    end
  end
endmodule

// File: rtl/cond_seq.sv
`timescale 1ns/1ps
// Phase sequencer for the two bus lines.
module cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             is_start,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] hold_len,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             done,
  output logic             clr_pulse,
  output logic             running,
  output logic             kind_out
);
  phase_e           phase_q;
  kind_e            kind_q;
  logic             expire;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;

  assign running  = (phase_q != PH_IDLE);
  assign kind_out = (kind_q == KIND_START);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (accept) begin
      cnt_load = 1'b1;
      cnt_val  = setup_len - 1'b1;
    end else if (phase_q == PH_SETUP && expire) begin
      cnt_load = 1'b1;
      cnt_val  = hold_len - 1'b1;
    end
  end

  cond_down_cnt #(.CNT_W(CNT_W)) u_phase_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      kind_q    <= KIND_STOP;
      scl_pull  <= 1'b0;
      sda_pull  <= 1'b0;
      done      <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      done      <= 1'b0;
      clr_pulse <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q  <= PH_SETUP;
            kind_q   <= is_start ? KIND_START : KIND_STOP;
            scl_pull <= 1'b0;
            sda_pull <= !is_start;
          end
        end
        PH_SETUP: begin
          if (expire) begin
            phase_q  <= PH_HOLD;
            sda_pull <= (kind_q == KIND_START);
          end
        end
        PH_HOLD: begin
          if (expire) begin
            phase_q   <= PH_IDLE;
            scl_pull  <= (kind_q == KIND_START);
            done      <= 1'b1;
            clr_pulse <= (kind_q == KIND_START);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cond_busy.sv
`timescale 1ns/1ps
// Bus-busy flag that follows an accepted command after a fixed delay.
module cond_busy #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             new_val,
  input  logic [CNT_W-1:0] delay_len,
  output logic             flag
);
  logic pend_q;
  logic expire;

  cond_down_cnt #(.CNT_W(CNT_W)) u_flag_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (delay_len - 1'b1),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (accept) pend_q <= new_val;
      if (expire) flag   <= pend_q;
    end
  end
endmodule

// File: rtl/i2c_cond_gen.sv
`timescale 1ns/1ps
module i2c_cond_gen #(
  parameter int CNT_W        = 8,
  parameter int STD_SU_START = 20,
  parameter int STD_SU_STOP  = 17,
  parameter int STD_HOLD     = 20,
  parameter int STD_FLAG     = 12,
  parameter int FST_SU_START = 10,
  parameter int FST_SU_STOP  = 7,
  parameter int FST_HOLD     = 10,
  parameter int FST_FLAG     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic if_enable,
  input  logic cmd_wr,
  input  logic cmd_master,
  input  logic cmd_xmit,
  input  logic cmd_busy,
  input  logic fast_mode,
  output logic scl_pull,
  output logic sda_pull,
  output logic bus_busy,
  output logic seq_done,
  output logic bitcnt_clr,
  output logic byte_req
);
  logic             accept;
  logic             mode_q;
  logic             mode_sel;
  logic             seq_running;
  logic             seq_kind;
  logic             start_sel;
  logic [CNT_W-1:0] setup_len;
  logic [CNT_W-1:0] hold_len;
  logic [CNT_W-1:0] flag_len;
  logic             clr_pulse;

  assign accept    = cmd_wr && if_enable && cmd_master && cmd_xmit && !seq_running;
  assign mode_sel  = accept ? fast_mode : mode_q;
  assign start_sel = accept ? cmd_busy : seq_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= 1'b0;
    else if (accept) mode_q <= fast_mode;
  end

  cond_timing #(
    .CNT_W(CNT_W),
    .STD_SU_START(STD_SU_START), .STD_SU_STOP(STD_SU_STOP),
    .STD_HOLD(STD_HOLD), .STD_FLAG(STD_FLAG),
    .FST_SU_START(FST_SU_START), .FST_SU_STOP(FST_SU_STOP),
    .FST_HOLD(FST_HOLD), .FST_FLAG(FST_FLAG)
  ) u_timing (
    .fast      (mode_sel),
    .is_start  (start_sel),
    .setup_len (setup_len),
    .hold_len  (hold_len),
    .flag_len  (flag_len)
  );

  cond_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .is_start  (cmd_busy),
    .setup_len (setup_len),
    .hold_len  (hold_len),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .done      (seq_done),
    .clr_pulse (clr_pulse),
    .running   (seq_running),
    .kind_out  (seq_kind)
  );

  cond_busy #(.CNT_W(CNT_W)) u_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .new_val   (cmd_busy),
    .delay_len (flag_len),
    .flag      (bus_busy)
  );

  assign bitcnt_clr = clr_pulse;
  assign byte_req   = clr_pulse;
endmodule

// File: rtl/i2c_cond_gen_chk.sv
`timescale 1ns/1ps
module i2c_cond_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic if_enable,
  input logic cmd_wr,
  input logic scl_pull,
  input logic sda_pull,
  input logic bus_busy,
  input logic seq_done,
  input logic bitcnt_clr,
  input logic byte_req,
  input logic run,
  input logic kind
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R7
  clr_with_start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_clr |-> (seq_done && byte_req && scl_pull && sda_pull));

  // R2
  start_end_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && kind) |-> (scl_pull && sda_pull));

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && $past(!scl_pull) && $fell(sda_pull)) |-> !kind);

  // R8
  run_ends_by_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (run || seq_done));

  // R6
  busy_moves_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_busy) |-> run);

  // R1
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && cmd_wr && !if_enable) |=> !run);
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .if_enable  (if_enable),
  .cmd_wr     (cmd_wr),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .bus_busy   (bus_busy),
  .seq_done   (seq_done),
  .bitcnt_clr (bitcnt_clr),
  .byte_req   (byte_req),
  .run        (seq_running),
  .kind       (seq_kind)
);

// File: tb/test_i2c_cond_gen.sv
`timescale 1ns/1ps
module test_i2c_cond_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic if_enable, cmd_wr, cmd_master, cmd_xmit, cmd_busy, fast_mode;
  logic scl_pull, sda_pull, bus_busy, seq_done, bitcnt_clr, byte_req;

  always #10 clk = ~clk;

  i2c_cond_gen i_i2c_cond_gen (
    .clk(clk), .rst_n(rst_n), .if_enable(if_enable), .cmd_wr(cmd_wr),
    .cmd_master(cmd_master), .cmd_xmit(cmd_xmit), .cmd_busy(cmd_busy),
    .fast_mode(fast_mode), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .bus_busy(bus_busy), .seq_done(seq_done), .bitcnt_clr(bitcnt_clr),
    .byte_req(byte_req)
  );

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 0;
  logic exp_scl, exp_sda, exp_busy;

  function automatic int su_len(bit st, bit f);
    if (st) return f ? 10 : 20;
    return f ? 7 : 17;
  endfunction
  function automatic int hold_len(bit f);
    return f ? 10 : 20;
  endfunction
  function automatic int flag_len(bit f);
    return f ? 6 : 12;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic check_all(input string lreq, input bit done_e, input bit clr_e);
    chk(scl_pull == exp_scl, lreq, "scl_pull", scl_pull, exp_scl);
    chk(sda_pull == exp_sda, lreq, "sda_pull", sda_pull, exp_sda);
    chk(bus_busy == exp_busy, "R6", "bus_busy", bus_busy, exp_busy);
    chk(seq_done == done_e, "R9", "seq_done", seq_done, done_e);
    chk(bitcnt_clr == clr_e, "R7", "bitcnt_clr", bitcnt_clr, clr_e);
    chk(byte_req == clr_e, "R7", "byte_req", byte_req, clr_e);
  endtask

  task automatic idle_watch(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      check_all(req, 1'b0, 1'b0);
    end
  endtask

  // One command; noisy adds stray writes and mode toggles while running (R8, R10)
  task automatic run_seq(input bit st, input bit f, input bit noisy);
    int s, h, b;
    string lreq;
    s = su_len(st, f);
    h = hold_len(f);
    b = flag_len(f);
    lreq = st ? (f ? "R2 R5" : "R2 R4") : (f ? "R3 R5" : "R3 R4");
    if (noisy) lreq = {lreq, " R8 R10"};
    if_enable = 1; cmd_master = 1; cmd_xmit = 1; cmd_busy = st; fast_mode = f;
    cmd_wr = 1;
    for (int j = 1; j <= s + h + 1; j++) begin
      tick();
      if (j <= s) begin
        exp_scl = 0; exp_sda = !st;
      end else if (j <= s + h) begin
        exp_scl = 0; exp_sda = st;
      end else begin
        exp_scl = st; exp_sda = st;
      end
      if (j == b + 1) exp_busy = st;
      check_all(lreq, j == s + h + 1, (j == s + h + 1) && st);
      if (noisy && j < s + h) begin
        cmd_wr     = $urandom_range(0, 1);
        cmd_master = $urandom_range(0, 3) != 0;
        cmd_xmit   = $urandom_range(0, 3) != 0;
        cmd_busy   = $urandom_range(0, 1);
        fast_mode  = $urandom_range(0, 1);
      end else begin
        cmd_wr = 0;
      end
    end
    cmd_wr = 0;
  endtask

  initial begin
    void'($urandom(32'd7311));
    rst_n = 0; if_enable = 0; cmd_wr = 0; cmd_master = 0; cmd_xmit = 0;
    cmd_busy = 0; fast_mode = 0;
    exp_scl = 0; exp_sda = 0; exp_busy = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R11 reset state
    check_all("R11", 1'b0, 1'b0);
    idle_watch(2, "R11");

    run_seq(1, 0, 0);
    idle_watch(3, "R7");
    run_seq(0, 0, 0);
    run_seq(1, 1, 0);
    run_seq(0, 1, 0);

    // R1 disabled writes
    if_enable = 0; cmd_master = 1; cmd_xmit = 1; cmd_busy = 1; cmd_wr = 1;
    idle_watch(1, "R1");
    cmd_wr = 0;
    idle_watch(25, "R1");

    // R12 incomplete command bits
    if_enable = 1; cmd_master = 0; cmd_xmit = 1; cmd_busy = 1; cmd_wr = 1;
    idle_watch(1, "R12");
    cmd_master = 1; cmd_xmit = 0;
    idle_watch(1, "R12");
    cmd_wr = 0;
    idle_watch(25, "R12");

    // repeated START, then STOP from held bus
    run_seq(1, 0, 0);
    run_seq(1, 1, 1);
    run_seq(0, 0, 1);

    for (int k = 0; k < 30; k++) begin
      run_seq($urandom_range(0, 1), $urandom_range(0, 1), 1);
      idle_watch($urandom_range(0, 3), "R9");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule